// File: doc/BRIEF.md
# Dual-Direction AES Byte Substitution

This unit maps one byte through the AES substitution box, in the forward direction for encryption or in the inverse direction for decryption. It is purely combinational. The output follows the data input and the direction input within the same cycle, with no register on the path. A full cipher state uses sixteen copies of the unit, one per byte.

Both directions share one 256-entry table of multiplicative inverses over GF(2^8). The table is built at elaboration from the field polynomial. Two affine stages sit around that table. The forward stage runs after the inversion. The inverse stage runs before it. Two multiplexers, driven by the direction input, route the byte through the stages in the right order, so no second substitution table is needed.

Top module: `aes_sbox_dual`

## Requirements
- R1: With `mode_i` = 0 (forward), input 0x00 produces 0x63.
- R2: In forward mode, inputs 0x53, 0x01 and 0xFF produce 0xED, 0x7C and 0x16.
- R3: With `mode_i` = 1 (inverse), inputs 0x63, 0xED and 0x16 produce 0x00, 0x53 and 0xFF.
- R4: For every byte x, feeding the forward result of x into inverse mode returns x.
- R5: For every byte x, feeding the inverse result of x into forward mode returns x.
- R6: In forward mode, no input maps to itself or to its bitwise complement.
- R7: In forward mode, the output is the affine map of the field inverse of the input. The field polynomial is 0x11B. The inverse of 0x00 is taken as 0x00. Output bit i is the XOR of inverse bits i, i+4, i+5, i+6 and i+7 (mod 8) and of bit i of 0x63.
- R8: Mode encoding: 0 selects forward and 1 selects inverse. With the data input held, changing `mode_i` changes the output in the same cycle, with no clock edge needed.
- R9: In inverse mode, the output is the field inverse of an inverse affine map of the input. Bit i of that map is the XOR of input bits i+2, i+5 and i+7 (mod 8) and of bit i of 0x05.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode_i | input | 1 | Direction select: 0 forward, 1 inverse |
| byte_i | input | 8 | Byte to substitute |
| byte_o | output | 8 | Substituted byte |

## Verification
The forward and inverse affine stages are both live on every input, and the shared inversion table serves whichever path the mode picks. A toggle of the mode therefore reroutes the same table within one cycle. The bench holds a byte steady, flips `mode_i` between two samples, and compares each sample with a bench-side model built from a brute-force field inverse and rotation-form affine maps. Full sweeps in both directions, plus round trips through both orders, show that the table and both stages agree for every byte.

// File: rtl/aes_sub_pkg.sv
package aes_sub_pkg;

    localparam int BYTE_W     = 8;
    localparam int FIELD_SIZE = 1 << BYTE_W;
    localparam int GROUP_ORD  = FIELD_SIZE - 1;

    typedef logic [BYTE_W-1:0]                  gf_byte_t;
    typedef logic [BYTE_W:0]                    gf_poly_t;
    typedef logic [FIELD_SIZE-1:0][BYTE_W-1:0]  gf_table_t;

    typedef enum logic {
        SUB_FWD = 1'b0,
        SUB_INV = 1'b1
    } sub_mode_e;

    localparam gf_byte_t FWD_AFF_C = 8'h63;
    localparam gf_byte_t INV_AFF_C = 8'h05;
    localparam gf_byte_t GEN_ELEM  = 8'h03;

    // multiply by x, reduced by the field polynomial
    function automatic gf_byte_t gf_xtime(gf_byte_t a, gf_poly_t poly);
        gf_byte_t sh;
        sh = {a[BYTE_W-2:0], 1'b0};
        return a[BYTE_W-1] ? (sh ^ poly[BYTE_W-1:0]) : sh;
    endfunction

    function automatic gf_byte_t gf_mul(gf_byte_t a, gf_byte_t b, gf_poly_t poly);
        gf_byte_t acc;
        gf_byte_t cur;
        acc = '0;
        cur = a;
        for (int k = 0; k < BYTE_W; k++) begin
            if (b[k]) acc = acc ^ cur;
            cur = gf_xtime(cur, poly);
        end
        return acc;
    endfunction

    // inverse table from powers of a generator: inv(g^k) = g^(ord-k)
    function automatic gf_table_t build_inv_table(gf_poly_t poly);
        gf_table_t pw;
        gf_table_t tbl;
        gf_byte_t  p;
        pw  = '0;
        tbl = '0;
        p   = 8'h01;
        for (int k = 0; k < GROUP_ORD; k++) begin
            pw[k] = p;
            p     = gf_mul(p, GEN_ELEM, poly);
        end
        for (int k = 0; k < GROUP_ORD; k++) begin
            tbl[pw[k]] = pw[(GROUP_ORD - k) % GROUP_ORD];
        end
        tbl[0] = '0;
        return tbl;
    endfunction

endpackage

// File: rtl/gf_inv_lut.sv
module gf_inv_lut
    import aes_sub_pkg::*;
#(
    parameter gf_poly_t POLY = 9'h11B
) (
    input  gf_byte_t a_i,
    output gf_byte_t inv_o
);

    localparam gf_table_t INV_TABLE = build_inv_table(POLY);

    assign inv_o = INV_TABLE[a_i];

endmodule

// File: rtl/gf_affine.sv
module gf_affine
    import aes_sub_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  gf_byte_t x_i,
    output gf_byte_t y_o
);

    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        if (!INVERSE) begin : g_fwd
            assign y_o[i] = x_i[i]
                          ^ x_i[(i + 4) % BYTE_W]
                          ^ x_i[(i + 5) % BYTE_W]
                          ^ x_i[(i + 6) % BYTE_W]
                          ^ x_i[(i + 7) % BYTE_W]
                          ^ FWD_AFF_C[i];
        end else begin : g_inv
            assign y_o[i] = x_i[(i + 2) % BYTE_W]
                          ^ x_i[(i + 5) % BYTE_W]
                          ^ x_i[(i + 7) % BYTE_W]
                          ^ INV_AFF_C[i];
        end
    end

endmodule

// File: rtl/aes_sbox_dual.sv
module aes_sbox_dual
    import aes_sub_pkg::*;
#(
    parameter gf_poly_t POLY = 9'h11B
) (
    input  logic        mode_i,
    input  logic [7:0]  byte_i,
    output logic [7:0]  byte_o
);

    sub_mode_e mode;
    gf_byte_t  pre_aff;
    gf_byte_t  inv_in;
    gf_byte_t  inv_out;
    gf_byte_t  post_aff;

    assign mode = sub_mode_e'(mode_i);

    // inverse direction: undo the affine map before inversion
    gf_affine #(.INVERSE(1'b1)) u_aff_pre (
        .x_i (byte_i),
        .y_o (pre_aff)
    );

    always_comb begin
        inv_in = (mode == SUB_INV) ? pre_aff : byte_i;
    end

    gf_inv_lut #(.POLY(POLY)) u_inv (
        .a_i   (inv_in),
        .inv_o (inv_out)
    );

    // forward direction: affine map after inversion
    gf_affine #(.INVERSE(1'b0)) u_aff_post (
        .x_i (inv_out),
        .y_o (post_aff)
    );

    always_comb begin
        byte_o = (mode == SUB_INV) ? inv_out : post_aff;
    end

endmodule

// File: rtl/aes_sbox_dual_chk.sv
module aes_sbox_dual_chk
    import aes_sub_pkg::*;
#(
    parameter gf_poly_t POLY = 9'h11B
) (
    input logic     mode_i,
    input gf_byte_t byte_i,
    input gf_byte_t byte_o,
    input gf_byte_t inv_in,
    input gf_byte_t inv_out
);

    always_comb begin
        if (!mode_i && byte_i == 8'h00) begin
            a_r1_zero_fwd: assert (byte_o == 8'h63);
        end
        if (mode_i && byte_i == 8'h63) begin
            a_r3_zero_inv: assert (byte_o == 8'h00);
        end
        if (!mode_i) begin
            a_r6_no_fixed: assert (byte_o != byte_i && byte_o != ~byte_i);
        end
        if (inv_in != 8'h00) begin
            a_r7_inv_product: assert (gf_mul(inv_in, inv_out, POLY) == 8'h01);
        end else begin
            a_r7_zero_inverse: assert (inv_out == 8'h00);
        end
    end

endmodule

bind aes_sbox_dual aes_sbox_dual_chk #(.POLY(POLY)) u_chk (
    .mode_i  (mode_i),
    .byte_i  (byte_i),
    .byte_o  (byte_o),
    .inv_in  (inv_in),
    .inv_out (inv_out)
);

// File: tb/aes_sbox_dual_test.sv
`timescale 1ns/1ps
module aes_sbox_dual_test;

    logic       clk = 1'b0;
    logic       mode_r = 1'b0;
    logic [7:0] byte_r = 8'h00;
    logic [7:0] out_w;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    aes_sbox_dual uut (
        .mode_i (mode_r),
        .byte_i (byte_r),
        .byte_o (out_w)
    );

    // ---------------- bench model ----------------
    function automatic logic [7:0] m_mul(logic [7:0] a, logic [7:0] b);
        logic [7:0] r = 8'h00;
        logic [7:0] c = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) r ^= c;
            c = c[7] ? ({c[6:0], 1'b0} ^ 8'h1B) : {c[6:0], 1'b0};
        end
        return r;
    endfunction

    function automatic logic [7:0] m_inv(logic [7:0] a);
        if (a == 8'h00) return 8'h00;
        for (int y = 1; y < 256; y++) begin
            if (m_mul(a, 8'(y)) == 8'h01) return 8'(y);
        end
        return 8'h00;
    endfunction

    function automatic logic [7:0] rotl(logic [7:0] x, int k);
        return 8'((x << k) | (x >> (8 - k)));
    endfunction

    function automatic logic [7:0] m_fwd(logic [7:0] x);
        logic [7:0] v = m_inv(x);
        return v ^ rotl(v, 1) ^ rotl(v, 2) ^ rotl(v, 3) ^ rotl(v, 4) ^ 8'h63;
    endfunction

    function automatic logic [7:0] m_rev(logic [7:0] x);
        return m_inv(rotl(x, 1) ^ rotl(x, 3) ^ rotl(x, 6) ^ 8'h05);
    endfunction

    // ---------------- helpers ----------------
    task automatic apply(input logic m, input logic [7:0] b, output logic [7:0] y);
        @(posedge clk);
        mode_r = m;
        byte_r = b;
        @(negedge clk);
        y = out_w;
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_start_state;
        logic [7:0] y;
        @(negedge clk);
        check("R1 initial forward 00", out_w, 8'h63);
        apply(1'b0, 8'h00, y);
        check("R1 forward 00", y, 8'h63);
    endtask

    task automatic t_known_values;
        logic [7:0] y;
        apply(1'b0, 8'h53, y); check("R2 forward 53", y, 8'hED);
        apply(1'b0, 8'h01, y); check("R2 forward 01", y, 8'h7C);
        apply(1'b0, 8'hFF, y); check("R2 forward FF", y, 8'h16);
        apply(1'b1, 8'h63, y); check("R3 inverse 63", y, 8'h00);
        apply(1'b1, 8'hED, y); check("R3 inverse ED", y, 8'h53);
        apply(1'b1, 8'h16, y); check("R3 inverse 16", y, 8'hFF);
    endtask

    task automatic t_sweep_forward;
        logic [7:0] y;
        for (int x = 0; x < 256; x++) begin
            apply(1'b0, 8'(x), y);
            check("R7 forward table", y, m_fwd(8'(x)));
            check("R6 no fixed point", 8'(y == 8'(x)), 8'h00);
            check("R6 no complement point", 8'(y == ~8'(x)), 8'h00);
        end
    endtask

    task automatic t_sweep_inverse;
        logic [7:0] y;
        for (int x = 0; x < 256; x++) begin
            apply(1'b1, 8'(x), y);
            check("R9 inverse table", y, m_rev(8'(x)));
        end
    endtask

    task automatic t_round_trips;
        logic [7:0] y;
        logic [7:0] z;
        for (int x = 0; x < 256; x++) begin
            apply(1'b0, 8'(x), y);
            apply(1'b1, y, z);
            check("R4 inverse of forward", z, 8'(x));
            apply(1'b1, 8'(x), y);
            apply(1'b0, y, z);
            check("R5 forward of inverse", z, 8'(x));
        end
    endtask

    task automatic t_mode_toggle;
        logic [7:0] y;
        logic [7:0] pick [4] = '{8'h00, 8'h53, 8'hA7, 8'hFF};
        foreach (pick[i]) begin
            apply(1'b0, pick[i], y);
            check("R8 held byte forward", y, m_fwd(pick[i]));
            @(posedge clk);
            mode_r = 1'b1;
            #1;
            check("R8 same-cycle inverse", out_w, m_rev(pick[i]));
            mode_r = 1'b0;
            #1;
            check("R8 same-cycle forward", out_w, m_fwd(pick[i]));
        end
    endtask

    initial begin
        t_start_state;
        t_known_values;
        t_sweep_forward;
        t_sweep_inverse;
        t_round_trips;
        t_mode_toggle;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule